// File: doc/BRIEF.md
# Temporal Silence Store Detector

This block watches committed stores aimed at a small table of tracked cache lines. It sorts every store that hits a tracked line into one of three kinds. A silent store writes bytes equal to what the line already holds. An intermediate store is the first write that moves a clean line away from its contents. A reverting store puts a changed line back to the exact 64-byte image it held before that first change. The block keeps that earlier image as the reference, and every store on a changed line is compared against it over the whole line.

A clean line enters the table through the capture port, usually on a fill or when a line is written back clean. After that, stores arrive one 8-byte word at a time, with a word offset and per-byte enables. The block merges the enabled bytes into its copy of the line. In the same cycle it compares the merged line with the current copy and with the reference. The result is a one-cycle pulse, registered, that carries the line address. Logic downstream can use a reversion pulse to tell other caches that their old copy is valid again. What that logic does with the pulse is outside this block.

Top module: `tss_detector`

## Requirements
- R1: While reset is held and in the first cycle after it, all three pulse outputs are low. After reset the table holds no lines, so stores raise no pulse until a line has been captured.
- R2: A capture (`cap_valid_i`) records `cap_line_i` as both the current copy and the reference of line `cap_addr_i`, and the line is then clean. A capture to a line that is already tracked overwrites both copies in place, and the line is clean again. A capture raises no pulse.
- R3: A store to a tracked line whose enabled bytes equal the bytes already held raises `silent_o`. This includes a store with all byte enables low. The line's state does not change.
- R4: The first store that changes a clean tracked line raises `interm_o`. The line's contents from just before that store become the reference.
- R5: A store that leaves a changed line equal to its reference across all 64 bytes raises `revert_o` and makes the line clean. The reference stays in place, so a later change followed by a return raises `interm_o` and then `revert_o` again.
- R6: A store that changes a line that already differs from its reference, and does not restore it, raises no pulse. The new bytes are still merged into the current copy.
- R7: Byte enable bit i writes data bits [8i+7:8i] into byte 8*w+i of the line, where w is `st_off_i`. Line bits [8k+7:8k] hold byte k. Bytes whose enables are low keep their old value.
- R8: All-zero data is an ordinary value. A line that was captured as zeros, changed, and then set back to zeros raises `revert_o`.
- R9: Up to 4 lines are tracked. A capture of a new line takes the lowest free entry. When no entry is free, it replaces the line that was allocated earliest, and the replacement raises no pulse. The dropped line becomes untracked.
- R10: A store presented in the same cycle as a capture is ignored. It raises no pulse and does not change any line.
- R11: A pulse appears in the cycle after the store is presented. At most one of the three pulses is high at a time, and `evt_addr_o` then equals the store's line address.
- R12: A store to a line that is not tracked raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_valid_i | input | 1 | Capture a clean line |
| cap_addr_i | input | 26 | Line address of the capture |
| cap_line_i | input | 512 | Clean line contents, byte k at bits [8k+7:8k] |
| st_valid_i | input | 1 | Committed store present |
| st_addr_i | input | 26 | Line address of the store |
| st_off_i | input | 3 | Word offset of the store within the line |
| st_data_i | input | 64 | Store data |
| st_be_i | input | 8 | Byte enables of the store |
| silent_o | output | 1 | Store did not change the line |
| interm_o | output | 1 | First change away from the clean image |
| revert_o | output | 1 | Line returned to its reference image |
| evt_addr_o | output | 26 | Line address of the classified store |

## Verification
The hardest state to reach from the ports is a reversion. A changed line only reverts when every byte the stores touched has been restored to the reference, and random data almost never does that by chance. The random stimulus therefore keeps a model of each line's reference and often writes a reference word straight back. Repeated restores across different words then walk a dirty line back to a full match. Directed sequences cover the other cases: a return to all zeros, a partial restore while another word still differs, eviction of the oldest line, and a store that collides with a capture.

// File: rtl/tss_pkg.sv
package tss_pkg;

  typedef enum logic [1:0] {
    K_NONE   = 2'd0,
    K_SILENT = 2'd1,
    K_INTERM = 2'd2,
    K_REVERT = 2'd3
  } st_kind_e;

endpackage

// File: rtl/tss_merge_cmp.sv
module tss_merge_cmp
  import tss_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8
) (
  input  logic [LINE_BYTES*8-1:0]                   cur_line_i,
  input  logic [LINE_BYTES*8-1:0]                   ref_line_i,
  input  logic                                      dirty_i,
  input  logic [$clog2(LINE_BYTES/WORD_BYTES)-1:0]  off_i,
  input  logic [WORD_BYTES*8-1:0]                   data_i,
  input  logic [WORD_BYTES-1:0]                     be_i,
  output logic [LINE_BYTES*8-1:0]                   new_line_o,
  output st_kind_e                                  kind_o
);

  localparam int OFF_W = $clog2(LINE_BYTES/WORD_BYTES);

  // Each line byte picks either the store lane that maps onto it or its old value.
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    localparam int WIDX = b / WORD_BYTES;
    localparam int LANE = b % WORD_BYTES;
    logic hit;
    assign hit = (off_i == OFF_W'(WIDX)) && be_i[LANE];
    assign new_line_o[8*b +: 8] = hit ? data_i[8*LANE +: 8] : cur_line_i[8*b +: 8];
  end

  always_comb begin
    if (new_line_o == cur_line_i)      kind_o = K_SILENT;
    else if (!dirty_i)                 kind_o = K_INTERM;
    else if (new_line_o == ref_line_i) kind_o = K_REVERT;
    else                               kind_o = K_NONE;
  end

endmodule

// File: rtl/tss_line_entry.sv
module tss_line_entry
  import tss_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_we_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [LINE_W-1:0] cap_line_i,
  input  logic              st_we_i,
  input  st_kind_e          st_kind_i,
  input  logic [LINE_W-1:0] st_line_i,
  output logic              vld_o,
  output logic [ADDR_W-1:0] tag_o,
  output logic [LINE_W-1:0] cur_o,
  output logic [LINE_W-1:0] ref_o,
  output logic              dirty_o
);

  logic              vld_q, vld_d;
  logic              dirty_q, dirty_d;
  logic [ADDR_W-1:0] tag_q;
  logic [LINE_W-1:0] cur_q, cur_d, ref_q, ref_d;
  logic              cur_en, ref_en;

  always_comb begin
    vld_d   = vld_q;
    dirty_d = dirty_q;
    cur_en  = 1'b0;
    ref_en  = 1'b0;
    cur_d   = st_line_i;
    ref_d   = cur_q;
    if (cap_we_i) begin
      vld_d   = 1'b1;
      dirty_d = 1'b0;
      cur_en  = 1'b1;
      ref_en  = 1'b1;
      cur_d   = cap_line_i;
      ref_d   = cap_line_i;
    end else if (st_we_i) begin
      cur_en = 1'b1;
      unique case (st_kind_i)
        K_INTERM: begin
          dirty_d = 1'b1;
          ref_en  = 1'b1;
        end
        K_REVERT: dirty_d = 1'b0;
        default:  dirty_d = dirty_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_we_i) tag_q <= cap_addr_i;
    if (cur_en)   cur_q <= cur_d;
    if (ref_en)   ref_q <= ref_d;
  end

  assign vld_o   = vld_q;
  assign tag_o   = tag_q;
  assign cur_o   = cur_q;
  assign ref_o   = ref_q;
  assign dirty_o = dirty_q;

endmodule

// File: rtl/tss_alloc.sv
module tss_alloc #(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] vld_i,
  input  logic               alloc_req_i,
  output logic [ENTRIES-1:0] alloc_oh_o
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0]   vic_q, vic_d;
  logic [ENTRIES-1:0] free_oh, vic_oh;
  logic               free_found;

  always_comb begin
    free_oh    = '0;
    free_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld_i[i] && !free_found) begin
        free_oh[i] = 1'b1;
        free_found = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_vic
    assign vic_oh[i] = (vic_q == IDX_W'(i));
  end

  assign alloc_oh_o = free_found ? free_oh : vic_oh;

  // Entries fill in index order, so the round-robin pointer always names the oldest line.
  always_comb begin
    vic_d = vic_q;
    if (alloc_req_i && !free_found) begin
      vic_d = (vic_q == IDX_W'(ENTRIES - 1)) ? '0 : vic_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vic_q <= '0;
    else        vic_q <= vic_d;
  end

endmodule

// File: rtl/tss_detector.sv
module tss_detector
  import tss_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int LINE_BYTES = 64,
  parameter int WORD_BYTES = 8,
  parameter int ENTRIES    = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cap_valid_i,
  input  logic [ADDR_W-1:0]                        cap_addr_i,
  input  logic [LINE_BYTES*8-1:0]                  cap_line_i,
  input  logic                                     st_valid_i,
  input  logic [ADDR_W-1:0]                        st_addr_i,
  input  logic [$clog2(LINE_BYTES/WORD_BYTES)-1:0] st_off_i,
  input  logic [WORD_BYTES*8-1:0]                  st_data_i,
  input  logic [WORD_BYTES-1:0]                    st_be_i,
  output logic                                     silent_o,
  output logic                                     interm_o,
  output logic                                     revert_o,
  output logic [ADDR_W-1:0]                        evt_addr_o
);

  localparam int LINE_W = LINE_BYTES * 8;

  logic [ENTRIES-1:0] vld, dirty, st_hit, cap_hit, alloc_oh, cap_we, st_we;
  logic [ADDR_W-1:0]  tag   [ENTRIES];
  logic [LINE_W-1:0]  cur_a [ENTRIES];
  logic [LINE_W-1:0]  ref_a [ENTRIES];

  logic [LINE_W-1:0] sel_cur, sel_ref, new_line;
  logic              sel_dirty, do_store, cap_miss;
  st_kind_e          kind;

  logic silent_q, interm_q, revert_q;
  logic silent_d, interm_d, revert_d;
  logic [ADDR_W-1:0] evt_addr_q;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign st_hit[i]  = vld[i] && (tag[i] == st_addr_i);
    assign cap_hit[i] = vld[i] && (tag[i] == cap_addr_i);
    assign cap_we[i]  = cap_valid_i && (cap_miss ? alloc_oh[i] : cap_hit[i]);
    assign st_we[i]   = do_store && st_hit[i] && (kind != K_SILENT);

    tss_line_entry #(
      .ADDR_W (ADDR_W),
      .LINE_W (LINE_W)
    ) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_we_i   (cap_we[i]),
      .cap_addr_i (cap_addr_i),
      .cap_line_i (cap_line_i),
      .st_we_i    (st_we[i]),
      .st_kind_i  (kind),
      .st_line_i  (new_line),
      .vld_o      (vld[i]),
      .tag_o      (tag[i]),
      .cur_o      (cur_a[i]),
      .ref_o      (ref_a[i]),
      .dirty_o    (dirty[i])
    );
  end

  assign cap_miss = ~|cap_hit;
  assign do_store = st_valid_i && !cap_valid_i && (|st_hit);

  tss_alloc #(
    .ENTRIES (ENTRIES)
  ) u_alloc (
    .clk         (clk),
    .rst_n       (rst_n),
    .vld_i       (vld),
    .alloc_req_i (cap_valid_i && cap_miss),
    .alloc_oh_o  (alloc_oh)
  );

  // One-hot select of the hit entry's state.
  always_comb begin
    sel_cur   = '0;
    sel_ref   = '0;
    sel_dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (st_hit[i]) begin
        sel_cur   = sel_cur | cur_a[i];
        sel_ref   = sel_ref | ref_a[i];
        sel_dirty = sel_dirty | dirty[i];
      end
    end
  end

  tss_merge_cmp #(
    .LINE_BYTES (LINE_BYTES),
    .WORD_BYTES (WORD_BYTES)
  ) u_cmp (
    .cur_line_i (sel_cur),
    .ref_line_i (sel_ref),
    .dirty_i    (sel_dirty),
    .off_i      (st_off_i),
    .data_i     (st_data_i),
    .be_i       (st_be_i),
    .new_line_o (new_line),
    .kind_o     (kind)
  );

  always_comb begin
    silent_d = do_store && (kind == K_SILENT);
    interm_d = do_store && (kind == K_INTERM);
    revert_d = do_store && (kind == K_REVERT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      silent_q <= 1'b0;
      interm_q <= 1'b0;
      revert_q <= 1'b0;
    end else begin
      silent_q <= silent_d;
      interm_q <= interm_d;
      revert_q <= revert_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_store) evt_addr_q <= st_addr_i;
  end

  assign silent_o   = silent_q;
  assign interm_o   = interm_q;
  assign revert_o   = revert_q;
  assign evt_addr_o = evt_addr_q;

endmodule

// File: rtl/tss_detector_chk.sv
module tss_detector_chk #(
  parameter int ADDR_W     = 26,
  parameter int WORD_BYTES = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cap_valid_i,
  input logic                  st_valid_i,
  input logic [ADDR_W-1:0]     st_addr_i,
  input logic [WORD_BYTES-1:0] st_be_i,
  input logic                  silent_o,
  input logic                  interm_o,
  input logic                  revert_o,
  input logic [ADDR_W-1:0]     evt_addr_o
);

  logic any_pulse;
  assign any_pulse = silent_o || interm_o || revert_o;

  // R11: classes are mutually exclusive
  a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({silent_o, interm_o, revert_o}));

  // R11: a pulse follows a presented store and carries its line address
  a_r11_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> $past(st_valid_i));

  a_r11_addr: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> (evt_addr_o == $past(st_addr_i)));

  // R10: a store colliding with a capture yields nothing
  a_r10_cap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid_i |=> !any_pulse);

  // R3: a store with no enabled bytes can only be silent
  a_r3_no_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid_i && !cap_valid_i && (st_be_i == '0)) |=> (!interm_o && !revert_o));

endmodule

bind tss_detector tss_detector_chk #(
  .ADDR_W     (ADDR_W),
  .WORD_BYTES (WORD_BYTES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cap_valid_i (cap_valid_i),
  .st_valid_i  (st_valid_i),
  .st_addr_i   (st_addr_i),
  .st_be_i     (st_be_i),
  .silent_o    (silent_o),
  .interm_o    (interm_o),
  .revert_o    (revert_o),
  .evt_addr_o  (evt_addr_o)
);

// File: tb/tb_tss_detector.sv
`timescale 1ns/1ps
module tb_tss_detector;

  localparam int AW = 26;
  localparam int LW = 512;
  localparam int NE = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cap_valid;
  logic [AW-1:0] cap_addr;
  logic [LW-1:0] cap_line;
  logic          st_valid;
  logic [AW-1:0] st_addr;
  logic [2:0]    st_off;
  logic [63:0]   st_data;
  logic [7:0]    st_be;
  logic          silent_o, interm_o, revert_o;
  logic [AW-1:0] evt_addr_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  tss_detector dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cap_valid_i (cap_valid),
    .cap_addr_i  (cap_addr),
    .cap_line_i  (cap_line),
    .st_valid_i  (st_valid),
    .st_addr_i   (st_addr),
    .st_off_i    (st_off),
    .st_data_i   (st_data),
    .st_be_i     (st_be),
    .silent_o    (silent_o),
    .interm_o    (interm_o),
    .revert_o    (revert_o),
    .evt_addr_o  (evt_addr_o)
  );

  // Reference model built from the requirements
  bit            m_vld   [NE];
  bit            m_dirty [NE];
  logic [AW-1:0] m_tag   [NE];
  logic [LW-1:0] m_cur   [NE];
  logic [LW-1:0] m_ref   [NE];
  int            m_vic;

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < NE; i++) if (m_vld[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [LW-1:0] m_merge(input logic [LW-1:0] cur, input logic [2:0] off,
                                            input logic [63:0] d, input logic [7:0] be);
    logic [LW-1:0] r = cur;
    for (int b = 0; b < 8; b++) if (be[b]) r[int'(off)*64 + b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    cap_valid = 1'b0; st_valid = 1'b0;
    cap_addr = '0; cap_line = '0; st_addr = '0; st_off = '0; st_data = '0; st_be = '0;
  endtask

  task automatic m_capture(input logic [AW-1:0] a, input logic [LW-1:0] line);
    int idx = m_find(a);
    if (idx < 0) begin
      for (int i = 0; i < NE; i++) if (!m_vld[i] && idx < 0) idx = i;
      if (idx < 0) begin
        idx = m_vic;
        m_vic = (m_vic + 1) % NE;
      end
    end
    m_vld[idx] = 1'b1; m_tag[idx] = a; m_cur[idx] = line; m_ref[idx] = line; m_dirty[idx] = 1'b0;
  endtask

  task automatic do_cap(input logic [AW-1:0] a, input logic [LW-1:0] line, input string req);
    cap_valid = 1'b1; cap_addr = a; cap_line = line;
    @(negedge clk);
    idle_inputs();
    chk({silent_o, interm_o, revert_o} == 3'b000, req, {silent_o, interm_o, revert_o}, 0);
    m_capture(a, line);
  endtask

  // Expected pulses {silent,interm,revert}; the requirement tag follows the expected class.
  task automatic do_store(input logic [AW-1:0] a, input logic [2:0] off, input logic [63:0] d,
                          input logic [7:0] be, input string req_in);
    int            idx = m_find(a);
    logic [2:0]    exp = 3'b000;
    logic [LW-1:0] nl;
    string         req = req_in;
    st_valid = 1'b1; st_addr = a; st_off = off; st_data = d; st_be = be;
    if (idx >= 0) begin
      nl = m_merge(m_cur[idx], off, d, be);
      if (nl == m_cur[idx]) exp = 3'b100;
      else if (!m_dirty[idx]) begin
        exp = 3'b010; m_ref[idx] = m_cur[idx]; m_dirty[idx] = 1'b1; m_cur[idx] = nl;
      end else if (nl == m_ref[idx]) begin
        exp = 3'b001; m_dirty[idx] = 1'b0; m_cur[idx] = nl;
      end else m_cur[idx] = nl;
    end
    if (req == "") begin
      if (idx < 0) req = "R12";
      else if (exp == 3'b100) req = "R3";
      else if (exp == 3'b010) req = "R4";
      else if (exp == 3'b001) req = "R5";
      else req = "R6";
    end
    @(negedge clk);
    idle_inputs();
    chk({silent_o, interm_o, revert_o} == exp, req, {silent_o, interm_o, revert_o}, exp);
    if (exp != 3'b000) chk(evt_addr_o == a, "R11", evt_addr_o, a);
  endtask

  function automatic logic [LW-1:0] rnd_line();
    logic [LW-1:0] r;
    for (int i = 0; i < LW / 32; i++) r[i*32 +: 32] = $urandom();
    return r;
  endfunction

  localparam logic [AW-1:0] LA = 26'h0000100, LB = 26'h0000200, LC = 26'h0000300,
                            LD = 26'h0000400, LE = 26'h0000500;

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog got=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [LW-1:0] pa;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NE; i++) begin m_vld[i] = 0; m_dirty[i] = 0; end
    m_vic = 0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({silent_o, interm_o, revert_o} == 3'b000, "R1", {silent_o, interm_o, revert_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({silent_o, interm_o, revert_o} == 3'b000, "R1", {silent_o, interm_o, revert_o}, 0);
    do_store(LA, 3'd0, 64'h1, 8'hff, "R1");

    pa = rnd_line();
    do_cap(LA, pa, "R2");
    do_store(LA, 3'd4, pa[4*64 +: 64], 8'hff, "R3");
    do_store(LA, 3'd1, 64'hdead_beef_dead_beef, 8'h00, "R3");
    do_store(LA, 3'd2, ~pa[2*64 +: 64], 8'h08, "R7");
    do_store(LA, 3'd5, ~pa[5*64 +: 64], 8'hff, "R6");
    do_store(LA, 3'd5, pa[5*64 +: 64], 8'hff, "R6");
    do_store(LA, 3'd2, pa[2*64 +: 64], 8'hff, "R5");
    do_store(LA, 3'd7, 64'h0123_4567_89ab_cdef, 8'h81, "R4");
    do_store(LA, 3'd7, pa[7*64 +: 64], 8'h81, "R5");

    do_cap(LB, '0, "R2");
    do_store(LB, 3'd3, 64'h0, 8'hff, "R8");
    do_store(LB, 3'd3, 64'h1, 8'h01, "R8");
    do_store(LB, 3'd3, 64'h0, 8'hff, "R8");

    do_store(LA, 3'd0, ~pa[63:0], 8'hff, "R4");
    pa = rnd_line();
    do_cap(LA, pa, "R2");
    do_store(LA, 3'd0, ~pa[63:0], 8'h01, "R2");

    do_cap(LC, rnd_line(), "R9");
    do_cap(LD, rnd_line(), "R9");
    do_cap(LE, rnd_line(), "R9");
    do_store(LA, 3'd0, ~pa[63:0], 8'hff, "R9");
    do_store(LB, 3'd1, 64'hffff, 8'hff, "R9");

    cap_valid = 1'b1; cap_addr = LC; cap_line = m_cur[m_find(LC)];
    st_valid = 1'b1; st_addr = LB; st_off = 3'd1; st_data = 64'h0; st_be = 8'hff;
    @(negedge clk);
    idle_inputs();
    chk({silent_o, interm_o, revert_o} == 3'b000, "R10", {silent_o, interm_o, revert_o}, 0);
    m_capture(LC, m_cur[m_find(LC)]);
    do_store(LB, 3'd1, 64'hffff, 8'hff, "R10");

    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a   = 26'h100 * (1 + ($urandom() % 6));
      int            idx = m_find(a);
      int            sel = $urandom() % 100;
      logic [2:0]    off = 3'($urandom());
      logic [63:0]   d;
      logic [7:0]    be;
      if (sel < 8) begin
        do_cap(a, ($urandom() % 3 == 0) ? '0 : rnd_line(), "R2");
      end else begin
        be = ($urandom() % 2 == 0) ? 8'hff : 8'($urandom());
        if (idx >= 0 && sel < 50) begin
          d = m_ref[idx][int'(off)*64 +: 64];
          be = 8'hff;
        end else if (idx >= 0 && sel < 65) begin
          d = m_cur[idx][int'(off)*64 +: 64];
        end else if (sel < 80) begin
          d = 64'h0;
        end else begin
          d = {$urandom(), $urandom()};
        end
        do_store(a, off, d, be, "");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule